// File: doc/BRIEF.md
# Display window command generator

This block produces the addressing command bytes that a page-organised monochrome display controller needs ahead of a pixel burst, and then passes the pixel bytes of that burst through to the same output stream. A request names a window by its start column, its width in columns, its start page, its page count and an addressing mode. The block turns it into command bytes, forwards pixel bytes from an upstream source, and marks every output byte as command or data. A downstream serial interface can use that mark to drive the display's data/command select line.

Two addressing modes are supported. In horizontal mode a column range command and a page range command are sent once, and then all pixel bytes of all pages follow. The block remembers the last window it programmed and leaves out any range command whose start and end have not changed. In page mode no range commands are sent. Each page instead gets a three-byte position preamble, followed by that page's pixel bytes. Fixed column and page offsets are parameters, and they are added to every request.

Top module: `disp_window_cmdgen`

## Requirements
- R1: After reset, req_ready is 1, out_valid is 0 and pix_ready is 0.
- R2: A horizontal request (req_mode = 0) whose column range differs from the stored one emits three command bytes (out_cmd = 1): 0x21, then the start column S = (req_col + COL_OFS) mod 256, then the end column (S + req_width - 1) mod 256.
- R3: A horizontal request whose page range differs from the stored one emits three command bytes: 0x22, then the start page P = req_page + PAGE_OFS, then the end page P + req_pages - 1. These bytes come after the column range bytes when both are sent.
- R4: The first horizontal request after reset always emits both range commands, column range first.
- R5: A range command is left out when its start and end both equal the last values programmed for it. The column and page ranges are judged separately. When both are unchanged, the first output byte is pixel data.
- R6: In horizontal mode, after the range commands, exactly req_width × req_pages pixel bytes are forwarded in arrival order with out_cmd = 0.
- R7: A page-mode request (req_mode = 1) sends no range command. For page i (counting from 0) it emits 0xB0 | ((P + i) mod 8), then 0x00 | S[3:0], then 0x10 | S[7:4], all with out_cmd = 1, and then req_width pixel bytes of that page.
- R8: A page-mode request leaves the stored window unchanged. A later horizontal request that repeats the window programmed before it sends no range command.
- R9: req_ready is 1 only when no burst is in progress. A request held during a burst is not taken, and req_ready returns to 1 in the cycle after the last byte of the burst is taken.
- R10: While out_ready is 0, a presented command byte and its marker stay unchanged until the byte is taken.
- R11: pix_ready is 1 only during the data phase and only when out_ready is 1. No pixel byte is taken during a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Window request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_mode | input | 1 | 0 horizontal addressing, 1 page addressing |
| req_col | input | 8 | Start column before offset |
| req_width | input | 8 | Number of columns, at least 1 |
| req_page | input | PG_W | Start page before offset |
| req_pages | input | PG_W+1 | Number of pages, at least 1 |
| pix_valid | input | 1 | Pixel byte present |
| pix_ready | output | 1 | Pixel byte taken |
| pix_byte | input | 8 | Pixel byte, one column of one page |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_byte | output | 8 | Command or pixel byte |
| out_cmd | output | 1 | 1 for a command byte, 0 for a pixel byte |

## Verification
Two events can fall in the same cycle: the downstream takes the last byte of a burst, and a new window request is presented. The bench keeps req_valid high for the whole of every burst. It requires req_ready to stay 0 on every cycle of the burst and to be 1 with nothing on the output in the cycle that follows the final transfer. The second pairing is a command byte stalled by out_ready while the pixel source already offers data. In the stalled vectors out_ready and pix_valid are toggled on different rhythms, and the bench checks that the command byte holds, that pix_ready stays low, and that the forwarded pixel sequence has no gap or repeat.

// File: rtl/wcg_pkg.sv
// Package: shared constants and types for the display window command generator.
// Assumes command bytes are 8 bits wide and that page numbers fit a 3-bit field.
package wcg_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] OP_COL_RANGE  = 8'h21;
    localparam logic [7:0] OP_PAGE_RANGE = 8'h22;
    localparam logic [7:0] OP_PAGE_SEL   = 8'hB0;
    localparam logic [7:0] OP_COL_LOW    = 8'h00;
    localparam logic [7:0] OP_COL_HIGH   = 8'h10;

    typedef struct packed {
        logic [7:0] cs;
        logic [7:0] ce;
        logic [7:0] ps;
        logic [7:0] pe;
    } window_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_COL_OP, S_COL_START, S_COL_END,
        S_PG_OP,  S_PG_START,  S_PG_END,
        S_POS_PG, S_POS_CLO,   S_POS_CHI,
        S_DATA
    } phase_t;

endpackage

// File: rtl/wcg_window.sv
// Module: window arithmetic and the last-programmed window store.
// Applies the fixed offsets, forms inclusive end addresses and flags which
// range commands differ from the store. Horizontal requests update the store
// on acceptance; page requests never touch it. Assumes width and page count >= 1.
module wcg_window
    import wcg_pkg::*;
#(
    parameter int COL_OFS  = 0,
    parameter int PAGE_OFS = 1,
    parameter int PG_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_mode,
    input  logic [7:0]        req_col,
    input  logic [7:0]        req_width,
    input  logic [PG_W-1:0]   req_page,
    input  logic [PG_W:0]     req_pages,
    output window_t           win,
    output logic              col_dirty,
    output logic              pg_dirty
);

    localparam logic [7:0] COL_OFS8 = 8'(COL_OFS);
    localparam logic [7:0] PG_OFS8  = 8'(PAGE_OFS);
    localparam logic [7:0] ONE8     = 8'd1;

    window_t st;
    logic    st_vld;

    // Offset and end-address arithmetic for the requested window.
    always_comb begin
        win.cs = req_col + COL_OFS8;
        win.ce = win.cs + req_width - ONE8;
        win.ps = {{(8-PG_W){1'b0}}, req_page} + PG_OFS8;
        win.pe = win.ps + {{(7-PG_W){1'b0}}, req_pages} - ONE8;
    end

    // Compare each range against what was last programmed.
    always_comb begin
        col_dirty = !st_vld || (win.cs != st.cs) || (win.ce != st.ce);
        pg_dirty  = !st_vld || (win.ps != st.ps) || (win.pe != st.pe);
    end

    // Record the window when a horizontal request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_vld <= 1'b0;
            st     <= '0;
        end else if (accept && !req_mode) begin
            st_vld <= 1'b1;
            st     <= win;
        end
    end

    // R8: page-mode requests leave the store alone
    a_r8_page_keeps_store: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mode) |=> ($stable(st) && $stable(st_vld)));

endmodule

// File: rtl/wcg_seq.sv
// Module: byte sequencer. On a start pulse it latches the window and walks the
// command states for the chosen mode, then forwards pixel bytes column by column
// and page by page. Command bytes are driven from registers, so they hold under
// backpressure; pixel bytes pass straight from the upstream source.
module wcg_seq
    import wcg_pkg::*;
#(
    parameter int PG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  window_t           win,
    input  logic              col_dirty,
    input  logic              pg_dirty,
    input  logic [7:0]        width,
    input  logic [PG_W:0]     pages,
    input  logic              pix_valid,
    input  logic [7:0]        pix_byte,
    input  logic              out_ready,
    output logic              idle,
    output logic              pix_ready,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              out_cmd
);

    localparam logic [PG_W:0] PG_ONE = 1;
    localparam logic [7:0]    ONE8   = 8'd1;

    phase_t          state;
    window_t         w_r;
    logic [7:0]      width_r;
    logic [PG_W:0]   pages_r;
    logic            mode_r;
    logic            pg_dirty_r;
    logic [7:0]      col_cnt;
    logic [PG_W:0]   pg_cnt;
    logic [PG_W-1:0] pnum;
    logic            fire;
    logic            last_col;
    logic            last_pg;

    assign pnum     = w_r.ps[PG_W-1:0] + pg_cnt[PG_W-1:0];
    assign fire     = out_valid && out_ready;
    assign last_col = (col_cnt == width_r - ONE8);
    assign last_pg  = (pg_cnt == pages_r - PG_ONE);
    assign idle     = (state == S_IDLE);

    // Phase register, request snapshot and column/page counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            w_r        <= '0;
            width_r    <= '0;
            pages_r    <= '0;
            mode_r     <= 1'b0;
            pg_dirty_r <= 1'b0;
            col_cnt    <= '0;
            pg_cnt     <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    w_r        <= win;
                    width_r    <= width;
                    pages_r    <= pages;
                    mode_r     <= mode;
                    pg_dirty_r <= pg_dirty;
                    col_cnt    <= '0;
                    pg_cnt     <= '0;
                    if (mode)           state <= S_POS_PG;
                    else if (col_dirty) state <= S_COL_OP;
                    else if (pg_dirty)  state <= S_PG_OP;
                    else                state <= S_DATA;
                end
                S_COL_OP:    if (fire) state <= S_COL_START;
                S_COL_START: if (fire) state <= S_COL_END;
                S_COL_END:   if (fire) state <= pg_dirty_r ? S_PG_OP : S_DATA;
                S_PG_OP:     if (fire) state <= S_PG_START;
                S_PG_START:  if (fire) state <= S_PG_END;
                S_PG_END:    if (fire) state <= S_DATA;
                S_POS_PG:    if (fire) state <= S_POS_CLO;
                S_POS_CLO:   if (fire) state <= S_POS_CHI;
                S_POS_CHI:   if (fire) state <= S_DATA;
                S_DATA: if (fire) begin
                    if (last_col) begin
                        col_cnt <= '0;
                        if (last_pg) begin
                            state <= S_IDLE;
                        end else begin
                            pg_cnt <= pg_cnt + PG_ONE;
                            state  <= mode_r ? S_POS_PG : S_DATA;
                        end
                    end else begin
                        col_cnt <= col_cnt + ONE8;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output byte selection per phase; pixel phase is a pass-through.
    always_comb begin
        out_valid = 1'b1;
        out_cmd   = 1'b1;
        pix_ready = 1'b0;
        out_byte  = 8'h00;
        case (state)
            S_IDLE:      out_valid = 1'b0;
            S_COL_OP:    out_byte  = OP_COL_RANGE;
            S_COL_START: out_byte  = w_r.cs;
            S_COL_END:   out_byte  = w_r.ce;
            S_PG_OP:     out_byte  = OP_PAGE_RANGE;
            S_PG_START:  out_byte  = w_r.ps;
            S_PG_END:    out_byte  = w_r.pe;
            S_POS_PG:    out_byte  = OP_PAGE_SEL | {{(8-PG_W){1'b0}}, pnum};
            S_POS_CLO:   out_byte  = OP_COL_LOW  | {4'h0, w_r.cs[3:0]};
            S_POS_CHI:   out_byte  = OP_COL_HIGH | {4'h0, w_r.cs[7:4]};
            S_DATA: begin
                out_valid = pix_valid;
                out_cmd   = 1'b0;
                out_byte  = pix_byte;
                pix_ready = out_ready;
            end
            default:     out_valid = 1'b0;
        endcase
    end

    // R10: a stalled command byte holds its value and marker
    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cmd && !out_ready) |=> (out_valid && out_cmd && $stable(out_byte)));

    // R11: no pixel byte is taken unless downstream takes a data byte
    a_r11_pix_gate: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> (out_ready && !out_cmd));

    // R6: the column counter stays inside the requested width
    a_r6_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA) |-> (col_cnt < width_r));

    // R7: page-mode bursts never carry a range opcode
    a_r7_no_range_op: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cmd && mode_r && !idle) |->
            (out_byte != OP_COL_RANGE && out_byte != OP_PAGE_RANGE));

endmodule

// File: rtl/disp_window_cmdgen.sv
// Module: top of the display window command generator. Accepts one window
// request at a time, only while idle, and emits the addressing command bytes
// followed by the forwarded pixel bytes on one marked byte stream.
// Assumes req_width >= 1 and 1 <= req_pages <= 2**PG_W.
module disp_window_cmdgen
    import wcg_pkg::*;
#(
    parameter int COL_OFS  = 0,
    parameter int PAGE_OFS = 1,
    parameter int PG_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_mode,
    input  logic [7:0]        req_col,
    input  logic [7:0]        req_width,
    input  logic [PG_W-1:0]   req_page,
    input  logic [PG_W:0]     req_pages,
    input  logic              pix_valid,
    output logic              pix_ready,
    input  logic [7:0]        pix_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              out_cmd
);

    window_t win;
    logic    col_dirty;
    logic    pg_dirty;
    logic    idle;
    logic    accept;
    logic    h_seen;

    assign req_ready = idle;
    assign accept    = req_valid && idle;

    wcg_window #(
        .COL_OFS  (COL_OFS),
        .PAGE_OFS (PAGE_OFS),
        .PG_W     (PG_W)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_mode  (req_mode),
        .req_col   (req_col),
        .req_width (req_width),
        .req_page  (req_page),
        .req_pages (req_pages),
        .win       (win),
        .col_dirty (col_dirty),
        .pg_dirty  (pg_dirty)
    );

    wcg_seq #(
        .PG_W (PG_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .mode      (req_mode),
        .win       (win),
        .col_dirty (col_dirty),
        .pg_dirty  (pg_dirty),
        .width     (req_width),
        .pages     (req_pages),
        .pix_valid (pix_valid),
        .pix_byte  (pix_byte),
        .out_ready (out_ready),
        .idle      (idle),
        .pix_ready (pix_ready),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_cmd   (out_cmd)
    );

    // Tracks whether a horizontal request has been taken since reset (checking only).
    always_ff @(posedge clk) begin
        if (!rst_n)                  h_seen <= 1'b0;
        else if (accept && !req_mode) h_seen <= 1'b1;
    end

    // R9: a request is only taken with nothing in flight on the output
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> !out_valid);

    // R4: first horizontal request after reset opens with the column range opcode
    a_r4_first_col_op: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_mode && !h_seen) |=>
            (out_valid && out_cmd && out_byte == OP_COL_RANGE));

endmodule

// File: tb/sim_disp_window_cmdgen.sv
`timescale 1ns/1ps
module sim_disp_window_cmdgen;

    localparam int COLO  = 2;
    localparam int PAGEO = 1;
    localparam int NV    = 9;

    // {mode, col, width, page, pages, stall}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'd4, 3'd0, 4'd2, 1'b0},
        {1'b0, 8'h00, 8'd4, 3'd0, 4'd2, 1'b0},
        {1'b0, 8'h00, 8'd4, 3'd2, 4'd2, 1'b0},
        {1'b0, 8'h05, 8'd4, 3'd2, 4'd2, 1'b1},
        {1'b1, 8'h13, 8'd3, 3'd6, 4'd3, 1'b0},
        {1'b0, 8'h05, 8'd4, 3'd2, 4'd2, 1'b0},
        {1'b0, 8'hFE, 8'd4, 3'd1, 4'd1, 1'b1},
        {1'b1, 8'h00, 8'd1, 3'd0, 4'd1, 1'b1},
        {1'b0, 8'hF0, 8'd8, 3'd7, 4'd1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_mode = 1'b0;
    logic [7:0] req_col = '0;
    logic [7:0] req_width = 8'd1;
    logic [2:0] req_page = '0;
    logic [3:0] req_pages = 4'd1;
    logic       pix_valid = 1'b0;
    logic       pix_ready;
    logic [7:0] pix_byte = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_byte;
    logic       out_cmd;

    int checks = 0;
    int fails  = 0;

    logic [8:0] exp_b [128];
    int         exp_t [128];
    int         exp_n;
    logic [7:0] pix_seq = 8'h40;
    logic       m_vld = 1'b0;
    logic [7:0] m_cs, m_ce, m_ps, m_pe;
    logic       last_pg_mode = 1'b0;

    always #4 clk = ~clk;

    disp_window_cmdgen #(.COL_OFS(COLO), .PAGE_OFS(PAGEO), .PG_W(3)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
        .req_col(req_col), .req_width(req_width), .req_page(req_page), .req_pages(req_pages),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_byte(pix_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .out_cmd(out_cmd)
    );

    function automatic string tagname(input int k);
        case (k)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
        end
    endtask

    task automatic push(input logic cmd, input logic [7:0] b, input int t);
        exp_b[exp_n] = {cmd, b};
        exp_t[exp_n] = t;
        exp_n++;
    endtask

    // Expected byte sequence from the requirements, with the bench's own window store.
    task automatic build(input logic md, input logic [7:0] col, input logic [7:0] w,
                         input logic [2:0] pg, input logic [3:0] np);
        logic [7:0] cs, ce, ps, pe, d;
        bit first_skip;
        cs = col + 8'(COLO);
        ce = cs + w - 8'd1;
        ps = {5'd0, pg} + 8'(PAGEO);
        pe = ps + {4'd0, np} - 8'd1;
        d  = pix_seq;
        exp_n = 0;
        if (!md) begin
            first_skip = 1'b0;
            if (!m_vld || cs != m_cs || ce != m_ce) begin
                push(1'b1, 8'h21, m_vld ? 2 : 4);
                push(1'b1, cs, 2);
                push(1'b1, ce, 2);
            end else first_skip = 1'b1;
            if (!m_vld || ps != m_ps || pe != m_pe) begin
                push(1'b1, 8'h22, m_vld ? 3 : 4);
                push(1'b1, ps, 3);
                push(1'b1, pe, 3);
            end else if (first_skip) first_skip = 1'b1;
            for (int k = 0; k < int'(w) * int'(np); k++) begin
                push(1'b0, d, 6);
                d = d + 8'd1;
            end
            if (first_skip) exp_t[0] = last_pg_mode ? 8 : 5;
            m_vld = 1'b1; m_cs = cs; m_ce = ce; m_ps = ps; m_pe = pe;
            last_pg_mode = 1'b0;
        end else begin
            for (int p = 0; p < int'(np); p++) begin
                push(1'b1, 8'hB0 | {5'd0, 3'(ps + 8'(p))}, 7);
                push(1'b1, {4'h0, cs[3:0]}, 7);
                push(1'b1, {4'h1, cs[7:4]}, 7);
                for (int k = 0; k < int'(w); k++) begin
                    push(1'b0, d, 7);
                    d = d + 8'd1;
                end
            end
            last_pg_mode = 1'b1;
        end
    endtask

    task automatic run_burst(input logic [24:0] v);
        int idx, cyc;
        bit stall, prev_hold, exp_pr;
        logic [7:0] prev_b;
        stall = v[0];
        build(v[24], v[23:16], v[15:8], v[7:5], v[4:1]);
        @(negedge clk);
        req_mode = v[24]; req_col = v[23:16]; req_width = v[15:8];
        req_page = v[7:5]; req_pages = v[4:1]; req_valid = 1'b1;
        out_ready = 1'b0; pix_valid = 1'b0;
        #1;
        cyc = 0;
        while (!req_ready && cyc < 50) begin
            @(negedge clk); #1; cyc++;
        end
        idx = 0; cyc = 0; prev_hold = 1'b0; prev_b = '0;
        // Request stays asserted through the burst: it must not be taken again (R9).
        while (idx < exp_n && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            out_ready = stall ? (cyc % 3 != 1) : 1'b1;
            pix_valid = stall ? (cyc % 5 != 2) : 1'b1;
            pix_byte  = pix_seq;
            #1;
            chk(req_ready == 1'b0, "R9", req_ready, 0);
            if (prev_hold)
                chk(out_valid && out_cmd && out_byte == prev_b, "R10",
                    {out_valid, out_cmd, out_byte}, {2'b11, prev_b});
            exp_pr = out_ready && !exp_b[idx][8];
            chk(pix_ready == exp_pr, "R11", pix_ready, exp_pr);
            prev_hold = out_valid && out_cmd && !out_ready;
            prev_b    = out_byte;
            if (pix_valid && pix_ready) pix_seq = pix_seq + 8'd1;
            if (out_valid && out_ready) begin
                chk({out_cmd, out_byte} == exp_b[idx], tagname(exp_t[idx]),
                    {out_cmd, out_byte}, exp_b[idx]);
                idx++;
            end
        end
        if (idx < exp_n) chk(1'b0, "R6", idx, exp_n);
        @(negedge clk);
        req_valid = 1'b0; out_ready = 1'b1; pix_valid = 1'b0;
        #1;
        chk(req_ready == 1'b1 && out_valid == 1'b0, "R9", {req_ready, out_valid}, 2'b10);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        pix_valid = 1'b1;
        out_ready = 1'b1;
        #1;
        // R1: reset state (request input idle, sources active)
        chk(req_ready == 1'b1, "R1", req_ready, 1);
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        chk(pix_ready == 1'b0, "R1", pix_ready, 0);
        @(negedge clk);
        rst_n = 1'b1;
        pix_valid = 1'b0;
        #1;
        chk(req_ready == 1'b1 && out_valid == 1'b0 && pix_ready == 1'b0, "R1",
            {req_ready, out_valid, pix_ready}, 3'b100);

        for (int i = 0; i < NV; i++) run_burst(VEC[i]);

        // Directed: reset mid-run clears the window store, so a repeat sends both ranges (R4).
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(req_ready == 1'b1 && out_valid == 1'b0, "R1", {req_ready, out_valid}, 2'b10);
        @(negedge clk);
        rst_n = 1'b1;
        m_vld = 1'b0;
        last_pg_mode = 1'b0;
        run_burst(VEC[NV-1]);
        // Directed: the same window once more must be data only (R5).
        run_burst({VEC[NV-1][24:1], 1'b1});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule